// File: doc/BRIEF.md
# Configurable GPIO Port Cell

The block is one general-purpose I/O port of `WIDTH` pins (16 by default). Four per-pin registers on a small register bus shape each pin: a data buffer, an attribute, a direction and a mask. The direction bit sets whether the pin drives or listens. The attribute bit means one thing on a driven pin and another on a listening pin. On a driven pin it sets the output polarity. On a listening pin it turns the pull resistor on or off, and the data bit then picks pull-up or pull-down.

A mask bit takes the pin away from the GPIO logic and gives it to one of two special-function sources. A single port-wide select input picks which of the two sources is used. Pin inputs pass through a two-flop synchronizer. Software can read either the latched data buffer or the synchronized live pin level. A port-wide wakeup-enable input arms a detector. The detector raises a one-cycle wake request when a synchronized level changes on a pin that is a plain GPIO input.

Top module: `gpio_port_cell`

## Requirements
- R1: After reset every register reads 0. Every pin is then an undriven input with a pull-down (pull_en all ones, pull_up, pin_out and pin_oe all zeros), and wake_req is 0.
- R2: A GPIO pin (mask 0) whose direction bit is 1 has pin_oe set and its pull resistor off. A direction bit of 0 leaves pin_oe clear and pin_out at 0.
- R3: On a GPIO output, attribute 1 drives the data bit unchanged and attribute 0 drives its inverse.
- R4: On a GPIO input with attribute 0, pull_en is 1 and pull_up equals the data bit (1 pull-up, 0 pull-down). With attribute 1 both are 0 and the pin floats.
- R5: A pin whose mask bit is 1 takes pin_out and pin_oe from source 0 when sf_sel is 0 and from source 1 when sf_sel is 1, and has its pull resistor off.
- R6: Bus select codes: 1 reads and writes the data buffer, 2 the attribute, 3 the direction and 4 the mask. A write to code 0 also loads the data buffer. A write takes effect on the clock edge of the strobe.
- R7: Reading code 0 returns the pin level through a two-flop synchronizer. A level change shows on the read after two clock edges and not after one.
- R8: Codes 5 to 7 read as 0, and writes to them change no register.
- R9: With wake_en 1, a change on a pin with mask 0 and direction 0 gives exactly one one-cycle pulse on wake_req. There is no pulse when wake_en is 0 or when the pin is an output or masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | Register select code |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected code |
| sf_sel | input | 1 | Picks special-function source 0 or 1 for masked pins |
| wake_en | input | 1 | Arms the wakeup detector |
| sf0_out | input | 16 | Source 0 per-pin output values |
| sf0_oe | input | 16 | Source 0 per-pin output enables |
| sf1_out | input | 16 | Source 1 per-pin output values |
| sf1_oe | input | 16 | Source 1 per-pin output enables |
| pin_in | input | 16 | Live pad levels |
| pin_out | output | 16 | Per-pin drive value |
| pin_oe | output | 16 | Per-pin output enable |
| pull_en | output | 16 | Per-pin pull resistor enable |
| pull_up | output | 16 | Per-pin pull direction, 1 up and 0 down |
| wake_req | output | 1 | One-cycle wakeup request |

## Verification
A register write and wakeup detection can act in the same cycle. This happens when a direction write turns a pin into an output on the same edge at which that pin's pad level changes. The bench drives the strobe and the pin toggle together. It expects no wake pulse, because the change reaches the detector's eligibility gate only after the new direction is in force. A plain input toggle afterwards must still give exactly one pulse, which shows that the detector was not simply dead.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int SEL_W = 3;

  // bus register select codes
  typedef enum logic [SEL_W-1:0] {
    SEL_LEVEL = 3'd0,
    SEL_BUF   = 3'd1,
    SEL_ATTR  = 3'd2,
    SEL_DIR   = 3'd3,
    SEL_MASK  = 3'd4
  } gpio_sel_e;
endpackage

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] addr,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rdata,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] attr_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] mask_q
);
  logic [WIDTH-1:0] data_d, attr_d, dir_d, mask_d;
  logic             data_en, attr_en, dir_en, mask_en;

  // write decode, clock enables spelled out
  always_comb begin
    data_en = wr && ((addr == SEL_LEVEL) || (addr == SEL_BUF));
    attr_en = wr && (addr == SEL_ATTR);
    dir_en  = wr && (addr == SEL_DIR);
    mask_en = wr && (addr == SEL_MASK);
    data_d  = data_en ? wdata : data_q;
    attr_d  = attr_en ? wdata : attr_q;
    dir_d   = dir_en  ? wdata : dir_q;
    mask_d  = mask_en ? wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      attr_q <= '0;
      dir_q  <= '0;
      mask_q <= '0;
    end else begin
      data_q <= data_d;
      attr_q <= attr_d;
      dir_q  <= dir_d;
      mask_q <= mask_d;
    end
  end

  // read mux
  always_comb begin
    unique case (addr)
      SEL_LEVEL: rdata = level;
      SEL_BUF:   rdata = data_q;
      SEL_ATTR:  rdata = attr_q;
      SEL_DIR:   rdata = dir_q;
      SEL_MASK:  rdata = mask_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int WIDTH = 16
) (
  input  logic             sf_sel,
  input  logic [WIDTH-1:0] sf0_out,
  input  logic [WIDTH-1:0] sf0_oe,
  input  logic [WIDTH-1:0] sf1_out,
  input  logic [WIDTH-1:0] sf1_oe,
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] attr_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] mask_q,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pull_en,
  output logic [WIDTH-1:0] pull_up
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic sf_o, sf_e;

    always_comb begin
      sf_o = sf_sel ? sf1_out[i] : sf0_out[i];
      sf_e = sf_sel ? sf1_oe[i]  : sf0_oe[i];
    end

    always_comb begin
      pin_out[i] = 1'b0;
      pin_oe[i]  = 1'b0;
      pull_en[i] = 1'b0;
      pull_up[i] = 1'b0;
      if (mask_q[i]) begin
        // pin belongs to the selected special function
        pin_out[i] = sf_o;
        pin_oe[i]  = sf_e;
      end else if (dir_q[i]) begin
        // driven pin: attribute picks true or inverted polarity
        pin_oe[i]  = 1'b1;
        pin_out[i] = attr_q[i] ? data_q[i] : ~data_q[i];
      end else begin
        // listening pin: attribute 0 pulls, data picks up or down
        pull_en[i] = ~attr_q[i];
        pull_up[i] = ~attr_q[i] & data_q[i];
      end
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] level
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = pin_in;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign level = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_wake_det.sv
module gpio_wake_det #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] mask_q,
  input  logic             wake_en,
  output logic             wake_req
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] eligible;
  logic [WIDTH-1:0] changed;
  logic             wake_d;

  always_comb begin
    eligible = ~dir_q & ~mask_q;
    changed  = (level ^ prev_q) & eligible;
    wake_d   = wake_en && (|changed);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      wake_req <= 1'b0;
    end else begin
      prev_q   <= level;
      wake_req <= wake_d;
    end
  end
endmodule

// File: rtl/gpio_port_cell.sv
module gpio_port_cell
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic             sf_sel,
  input  logic             wake_en,
  input  logic [WIDTH-1:0] sf0_out,
  input  logic [WIDTH-1:0] sf0_oe,
  input  logic [WIDTH-1:0] sf1_out,
  input  logic [WIDTH-1:0] sf1_oe,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pull_en,
  output logic [WIDTH-1:0] pull_up,
  output logic             wake_req
);
  logic [1:0]       rst_ff;
  logic             rst_sync_n;
  logic [WIDTH-1:0] level;
  logic [WIDTH-1:0] data_q, attr_q, dir_q, mask_q;

  // reset: asserted at once, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_sync_n = rst_ff[1];

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pin_in (pin_in),
    .level  (level)
  );

  gpio_regbank #(.WIDTH(WIDTH)) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .addr   (bus_addr),
    .wr     (bus_wr),
    .wdata  (bus_wdata),
    .level  (level),
    .rdata  (bus_rdata),
    .data_q (data_q),
    .attr_q (attr_q),
    .dir_q  (dir_q),
    .mask_q (mask_q)
  );

  gpio_pin_mux #(.WIDTH(WIDTH)) u_mux (
    .sf_sel  (sf_sel),
    .sf0_out (sf0_out),
    .sf0_oe  (sf0_oe),
    .sf1_out (sf1_out),
    .sf1_oe  (sf1_oe),
    .data_q  (data_q),
    .attr_q  (attr_q),
    .dir_q   (dir_q),
    .mask_q  (mask_q),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .pull_en (pull_en),
    .pull_up (pull_up)
  );

  gpio_wake_det #(.WIDTH(WIDTH)) u_wake (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .level    (level),
    .dir_q    (dir_q),
    .mask_q   (mask_q),
    .wake_en  (wake_en),
    .wake_req (wake_req)
  );
endmodule

// File: rtl/gpio_port_cell_chk.sv
module gpio_port_cell_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic [2:0]       bus_addr,
  input logic             bus_wr,
  input logic [WIDTH-1:0] bus_wdata,
  input logic             wake_en,
  input logic             wake_req,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] pull_en,
  input logic [WIDTH-1:0] pull_up,
  input logic [WIDTH-1:0] data_q,
  input logic [WIDTH-1:0] attr_q,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] mask_q
);
  // R4: a pull direction is only meaningful with the pull enabled
  a_r4_up_needs_en: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((pull_up & ~pull_en) == '0));

  // R2: a driven pin never has its pull resistor on
  a_r2_no_pull_when_driven: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((pull_en & pin_oe) == '0));

  // R9: a wake pulse requires the detector to have been armed
  a_r9_wake_gated: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wake_req |-> $past(wake_en));

  // R6: a direction write lands on its strobe edge
  a_r6_dir_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == 3'd3) |=> (dir_q == $past(bus_wdata)));

  // R8: unused codes leave every register untouched
  a_r8_unused_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr >= 3'd5) |=>
      ($stable(data_q) && $stable(attr_q) && $stable(dir_q) && $stable(mask_q)));
endmodule

bind gpio_port_cell gpio_port_cell_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .wake_en    (wake_en),
  .wake_req   (wake_req),
  .pin_oe     (pin_oe),
  .pull_en    (pull_en),
  .pull_up    (pull_up),
  .data_q     (data_q),
  .attr_q     (attr_q),
  .dir_q      (dir_q),
  .mask_q     (mask_q)
);

// File: tb/gpio_port_cell_tb_top.sv
`timescale 1ns/1ps
module gpio_port_cell_tb_top;
  logic        clk;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic        bus_wr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        sf_sel;
  logic        wake_en;
  logic [15:0] sf0_out, sf0_oe, sf1_out, sf1_oe;
  logic [15:0] pin_in;
  logic [15:0] pin_out, pin_oe, pull_en, pull_up;
  logic        wake_req;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  gpio_port_cell dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sf_sel(sf_sel),
    .wake_en(wake_en), .sf0_out(sf0_out), .sf0_oe(sf0_oe),
    .sf1_out(sf1_out), .sf1_oe(sf1_oe), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pull_en(pull_en),
    .pull_up(pull_up), .wake_req(wake_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // rows: dir, attr, data, mask, sel, exp out, exp oe, exp pull_en, exp pull_up
  localparam logic [8:0][15:0] VEC [7] = '{
    '{16'hFF00, 16'hF0F0, 16'hCCCC, 16'h0000, 16'h0000, 16'hC300, 16'hFF00, 16'h000F, 16'h000C},
    '{16'h0000, 16'h0000, 16'hA5A5, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 16'hA5A5},
    '{16'hFFFF, 16'h0000, 16'h0F0F, 16'h0000, 16'h0000, 16'hF0F0, 16'hFFFF, 16'h0000, 16'h0000},
    '{16'hFFFF, 16'hFFFF, 16'h1234, 16'h0000, 16'h0000, 16'h1234, 16'hFFFF, 16'h0000, 16'h0000},
    '{16'hFFFF, 16'hFFFF, 16'h0000, 16'h00FF, 16'h0000, 16'h0055, 16'hFF0F, 16'h0000, 16'h0000},
    '{16'hFFFF, 16'hFFFF, 16'h0000, 16'h00FF, 16'h0001, 16'h00AA, 16'hFFF0, 16'h0000, 16'h0000},
    '{16'h0000, 16'h00FF, 16'hFFFF, 16'hF000, 16'h0001, 16'hA000, 16'hF000, 16'h0F00, 16'h0F00}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic count_wake(input int cycles, output int n);
    n = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (wake_req) n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int n;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    sf_sel = 1'b0; wake_en = 1'b0; pin_in = '0;
    sf0_out = 16'h5555; sf0_oe = 16'h0F0F; sf1_out = 16'hAAAA; sf1_oe = 16'hF0F0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    #1;
    check("R1 pin_oe", pin_oe, 16'h0000);
    check("R1 pin_out", pin_out, 16'h0000);
    check("R1 pull_en", pull_en, 16'hFFFF);
    check("R1 pull_up", pull_up, 16'h0000);
    check("R1 wake_req", {15'd0, wake_req}, 16'h0000);
    for (int a = 1; a <= 4; a++) begin
      bus_read(3'(a), rd);
      check("R1 register", rd, 16'h0000);
    end

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < 7; i++) begin
      bus_write(3'd3, VEC[i][8]);
      bus_write(3'd2, VEC[i][7]);
      bus_write(3'd1, VEC[i][6]);
      bus_write(3'd4, VEC[i][5]);
      sf_sel = VEC[i][4][0];
      #1;
      check("R3 R5 pin_out", pin_out, VEC[i][3]);
      check("R2 R5 pin_oe", pin_oe, VEC[i][2]);
      check("R4 pull_en", pull_en, VEC[i][1]);
      check("R4 pull_up", pull_up, VEC[i][0]);
    end

    // R6 readback, write through code 0
    bus_write(3'd0, 16'h6C93);
    bus_read(3'd1, rd); check("R6 data via code 0", rd, 16'h6C93);
    bus_read(3'd2, rd); check("R6 attr", rd, 16'h00FF);
    bus_read(3'd3, rd); check("R6 dir", rd, 16'h0000);
    bus_read(3'd4, rd); check("R6 mask", rd, 16'hF000);

    // R8 unused codes
    bus_write(3'd5, 16'hFFFF);
    bus_write(3'd7, 16'hFFFF);
    bus_read(3'd5, rd); check("R8 read code 5", rd, 16'h0000);
    bus_read(3'd1, rd); check("R8 data kept", rd, 16'h6C93);
    bus_read(3'd2, rd); check("R8 attr kept", rd, 16'h00FF);
    bus_read(3'd3, rd); check("R8 dir kept", rd, 16'h0000);
    bus_read(3'd4, rd); check("R8 mask kept", rd, 16'hF000);

    // R7 synchronized level: not after one edge, visible after two
    bus_write(3'd4, 16'h0000);
    bus_addr = 3'd0;
    @(negedge clk);
    pin_in = 16'h3C3C;
    @(negedge clk); #1 check("R7 after one edge", bus_rdata, 16'h0000);
    @(negedge clk); #1 check("R7 after two edges", bus_rdata, 16'h3C3C);
    pin_in = 16'h0000;
    repeat (4) @(negedge clk);

    // R9 wakeup
    wake_en = 1'b1;
    @(negedge clk); pin_in[2] = 1'b1;
    count_wake(6, n); check("R9 input toggle", 16'(n), 16'd1);
    wake_en = 1'b0;
    @(negedge clk); pin_in[2] = 1'b0;
    count_wake(6, n); check("R9 disarmed", 16'(n), 16'd0);
    wake_en = 1'b1;
    bus_write(3'd4, 16'h0010);
    @(negedge clk); pin_in[4] = 1'b1;
    count_wake(6, n); check("R9 masked pin", 16'(n), 16'd0);

    // R9 direction write on the same edge as the pin change
    @(negedge clk);
    bus_addr = 3'd3; bus_wr = 1'b1; bus_wdata = 16'h0008; pin_in[3] = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    count_wake(6, n); check("R9 pin turned output", 16'(n), 16'd0);
    @(negedge clk); pin_in[2] = 1'b1;
    count_wake(6, n); check("R9 still alive", 16'(n), 16'd1);

    // R1 reset mid-run returns to reset state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1 check("R1 reset again pull_en", pull_en, 16'hFFFF);
    check("R1 reset again pin_oe", pin_oe, 16'h0000);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule